// File: doc/BRIEF.md
# NAND Flash Bus Command Sequencer

This block turns simple internal requests into strobe-level cycles on an 8-bit asynchronous NAND flash bus. A request names an operation (command byte, address bytes, data write or data read), the index of the flash device to select, and a byte count. Outgoing bytes come from a valid/ready transmit stream. Read bytes leave on a valid/ready receive stream. The block drives the command-latch and address-latch strobes, the active-low write and read strobes, eight active-low chip enables, and the output enable of the shared data bus.

Strobe timing is counted in system clocks. Three per-grade phase counts (fast, medium, slow) are configuration inputs, and a two-bit grade input picks one of them. Before a command byte goes out, the block waits until the open-drain ready/busy line reads high. A configurable limit bounds that wait. A page-geometry input selects small pages (512 bytes) or large pages (2048 bytes) and caps the length of each transfer.

The controller states are IDLE, WAIT_RDY, FETCH, SETUP, WR_LO, WR_HI, RD_LO, RD_HI and RX_OUT. The transitions are:
- IDLE to WAIT_RDY on an accepted command request.
- IDLE to FETCH on an address or write request.
- IDLE to RD_LO on a read request.
- WAIT_RDY to FETCH when the synchronised ready/busy line is high.
- WAIT_RDY to IDLE on timeout.
- FETCH to SETUP when a transmit byte is taken.
- SETUP to WR_LO, WR_LO to WR_HI, RD_LO to RD_HI and RD_HI to RX_OUT when a phase ends.
- WR_HI to FETCH (more bytes) or to IDLE (last byte) when its phase ends.
- RX_OUT to RD_LO (more bytes) or to IDLE (last byte) when the receiver accepts a byte.

Top module: `nand_bus_seq`

## Requirements
- R1: Out of reset and whenever no request is in progress: `req_ready`=1, `nf_ce_n`=8'hFF, `nf_we_n`=1, `nf_re_n`=1, `nf_cle`=0, `nf_ale`=0, `nf_dq_oe`=0.
- R2: From acceptance to completion of a request, only `nf_ce_n[req_cs]` is low. This includes the wait for ready.
- R3: Operation code 2'b00 (command) sends exactly one byte, whatever `req_len` holds. At the rising edge of `nf_we_n` the bus shows `nf_cle`=1, `nf_ale`=0 and `nf_dq_oe`=1, and `nf_dq_out` carries the transmit byte.
- R4: Operation code 2'b01 (address) sends `req_len`+1 transmit bytes in order. Each is latched on a rising `nf_we_n` with `nf_ale`=1 and `nf_cle`=0.
- R5: Operation code 2'b10 (write) sends `req_len`+1 transmit bytes in order. Each is latched on a rising `nf_we_n` with `nf_cle`=0, `nf_ale`=0 and `nf_dq_oe`=1.
- R6: Operation code 2'b11 (read) produces `req_len`+1 falling edges of `nf_re_n`, with `nf_dq_oe` low throughout. The value on `nf_dq_in` during each low phase is returned on `rx_data`, in order.
- R7: Every low phase of `nf_we_n` or `nf_re_n` lasts exactly P clocks. P is `cfg_ph_fast` for grade 0, `cfg_ph_mid` for grade 1, and `cfg_ph_slow` for grades 2 and 3. A count of 0 acts as 1.
- R8: `nf_cle`, `nf_ale` and `nf_dq_out` do not change on the clock where `nf_we_n` rises, and `nf_dq_oe` is high there.
- R9: When `cfg_page_big`=0 the byte count of an address, write or read request is capped at 512 (`req_len` above 511 acts as 511). When `cfg_page_big`=1 the cap is 2048.
- R10: A command request asserts no `nf_we_n` strobe while `nf_rb_n` is low. It proceeds after `nf_rb_n` returns high, with a lag of two synchroniser stages.
- R11: If `nf_rb_n` stays low for `cfg_busy_limit` clocks during the wait, the command is dropped with no strobe. The block returns to idle with `busy_err`=1. `busy_err` clears when the next request is accepted.
- R12: A missing transmit byte (`tx_valid`=0) holds `nf_we_n` high. A stalled receiver (`rx_ready`=0) delays the next `nf_re_n` fall. No byte is lost or repeated in either case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request accepted when valid |
| req_op | input | 2 | 00 command, 01 address, 10 write, 11 read |
| req_cs | input | 3 | Index of the device to select |
| req_len | input | 12 | Byte count minus one |
| tx_data | input | 8 | Outgoing byte |
| tx_valid | input | 1 | Outgoing byte available |
| tx_ready | output | 1 | Outgoing byte taken this clock when valid |
| rx_data | output | 8 | Byte read from flash |
| rx_valid | output | 1 | Read byte available |
| rx_ready | input | 1 | Receiver accepts read byte |
| cfg_grade | input | 2 | Timing grade select |
| cfg_ph_fast | input | 8 | Phase clocks, fast grade |
| cfg_ph_mid | input | 8 | Phase clocks, medium grade |
| cfg_ph_slow | input | 8 | Phase clocks, slow grade |
| cfg_page_big | input | 1 | 1: 2048-byte pages, 0: 512-byte pages |
| cfg_busy_limit | input | 16 | Ready-wait limit in clocks |
| busy_err | output | 1 | Last command dropped on ready timeout |
| nf_rb_n | input | 1 | Ready/busy line, low = busy |
| nf_ce_n | output | 8 | Active-low chip enables |
| nf_cle | output | 1 | Command latch strobe |
| nf_ale | output | 1 | Address latch strobe |
| nf_we_n | output | 1 | Active-low write strobe |
| nf_re_n | output | 1 | Active-low read strobe |
| nf_dq_out | output | 8 | Data bus output value |
| nf_dq_oe | output | 1 | Data bus output enable |
| nf_dq_in | input | 8 | Data bus input value |

## Verification
The assertions take the configuration inputs (grade, phase counts, page size) to be stable while a request is in progress, and the ready/busy line to stay high from the end of a ready wait until the command byte has been strobed. The stimulus changes configuration only when `req_ready` is high. It moves `nf_rb_n` only around command requests, and it releases the line before the wait ends. Random stalls are applied only on the transmit and receive streams, so they stay inside those limits.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    typedef enum logic [1:0] {
        OP_CMD   = 2'd0,
        OP_ADDR  = 2'd1,
        OP_WRITE = 2'd2,
        OP_READ  = 2'd3
    } nand_op_e;

    typedef enum logic [1:0] {
        GR_FAST  = 2'd0,
        GR_MID   = 2'd1,
        GR_SLOW  = 2'd2,
        GR_SLOW2 = 2'd3
    } grade_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WAIT_RDY,
        ST_FETCH,
        ST_SETUP,
        ST_WR_LO,
        ST_WR_HI,
        ST_RD_LO,
        ST_RD_HI,
        ST_RX_OUT
    } seq_state_e;

endpackage

// File: rtl/nand_phase_timer.sv
module nand_phase_timer
    import nand_seq_pkg::*;
#(
    parameter int PH_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart,
    input  logic [1:0]      grade,
    input  logic [PH_W-1:0] ph_fast,
    input  logic [PH_W-1:0] ph_mid,
    input  logic [PH_W-1:0] ph_slow,
    output logic            done
);

    logic [PH_W-1:0] sel_len;
    logic [PH_W-1:0] eff_len;
    logic [PH_W-1:0] cnt_q;

    // grade decode: both upper codes share the slow count
    always_comb begin
        unique case (grade_e'(grade))
            GR_FAST:  sel_len = ph_fast;
            GR_MID:   sel_len = ph_mid;
            GR_SLOW:  sel_len = ph_slow;
            GR_SLOW2: sel_len = ph_slow;
            default:  sel_len = ph_slow;
        endcase
        eff_len = (sel_len == '0) ? PH_W'(1) : sel_len;
    end

    assign done = (cnt_q >= (eff_len - PH_W'(1)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (!done) begin
            cnt_q <= cnt_q + PH_W'(1);
        end
    end

endmodule

// File: rtl/nand_rb_watch.sv
module nand_rb_watch #(
    parameter int TMO_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rb_n_async,
    input  logic             waiting,
    input  logic [TMO_W-1:0] limit,
    output logic             rb_ok,
    output logic             tmo
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [TMO_W-1:0]       wait_cnt_q;

    // synchroniser depth chosen by parameter; reset value reads as busy
    generate
        if (SYNC_STAGES == 1) begin : g_sync_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= rb_n_async;
            end
        end else begin : g_sync_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], rb_n_async};
            end
        end
    endgenerate

    assign rb_ok = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wait_cnt_q <= '0;
        end else if (!waiting) begin
            wait_cnt_q <= '0;
        end else if (!rb_ok && (wait_cnt_q != '1)) begin
            wait_cnt_q <= wait_cnt_q + TMO_W'(1);
        end
    end

    assign tmo = waiting && !rb_ok && (wait_cnt_q >= limit);

endmodule

// File: rtl/nand_len_ctr.sv
module nand_len_ctr #(
    parameter int LEN_W      = 12,
    parameter int PAGE_SMALL = 512,
    parameter int PAGE_BIG   = 2048
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             single,
    input  logic             page_big,
    input  logic [LEN_W-1:0] req_len,
    input  logic             dec,
    output logic             last
);

    localparam logic [LEN_W-1:0] MAX_SMALL = LEN_W'(PAGE_SMALL - 1);
    localparam logic [LEN_W-1:0] MAX_BIG   = LEN_W'(PAGE_BIG - 1);

    logic [LEN_W-1:0] pmax;
    logic [LEN_W-1:0] load_val;
    logic [LEN_W-1:0] rem_q;

    always_comb begin
        pmax = page_big ? MAX_BIG : MAX_SMALL;
        if (single)               load_val = '0;
        else if (req_len > pmax)  load_val = pmax;
        else                      load_val = req_len;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (load) begin
            rem_q <= load_val;
        end else if (dec && (rem_q != '0)) begin
            rem_q <= rem_q - LEN_W'(1);
        end
    end

    assign last = (rem_q == '0);

    // R9
    rem_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (rem_q <= $past(pmax)));

endmodule

// File: rtl/nand_bus_seq.sv
module nand_bus_seq
    import nand_seq_pkg::*;
#(
    parameter int NCE         = 8,
    parameter int DW          = 8,
    parameter int LEN_W       = 12,
    parameter int PH_W        = 8,
    parameter int TMO_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int PAGE_SMALL  = 512,
    parameter int PAGE_BIG    = 2048,
    localparam int CS_W       = $clog2(NCE)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [1:0]       req_op,
    input  logic [CS_W-1:0]  req_cs,
    input  logic [LEN_W-1:0] req_len,
    input  logic [DW-1:0]    tx_data,
    input  logic             tx_valid,
    output logic             tx_ready,
    output logic [DW-1:0]    rx_data,
    output logic             rx_valid,
    input  logic             rx_ready,
    input  logic [1:0]       cfg_grade,
    input  logic [PH_W-1:0]  cfg_ph_fast,
    input  logic [PH_W-1:0]  cfg_ph_mid,
    input  logic [PH_W-1:0]  cfg_ph_slow,
    input  logic             cfg_page_big,
    input  logic [TMO_W-1:0] cfg_busy_limit,
    output logic             busy_err,
    input  logic             nf_rb_n,
    output logic [NCE-1:0]   nf_ce_n,
    output logic             nf_cle,
    output logic             nf_ale,
    output logic             nf_we_n,
    output logic             nf_re_n,
    output logic [DW-1:0]    nf_dq_out,
    output logic             nf_dq_oe,
    input  logic [DW-1:0]    nf_dq_in
);

    seq_state_e      state_q, state_d;
    nand_op_e        op_q;
    logic [CS_W-1:0] cs_q;
    logic [DW-1:0]   byte_q;
    logic [DW-1:0]   rx_q;
    logic            err_q;

    logic accept, take_tx, cap_rx, dec_len, set_err;
    logic ph_done, rb_ok, tmo, last;
    logic drive_bus;

    nand_phase_timer #(.PH_W(PH_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (state_d != state_q),
        .grade   (cfg_grade),
        .ph_fast (cfg_ph_fast),
        .ph_mid  (cfg_ph_mid),
        .ph_slow (cfg_ph_slow),
        .done    (ph_done)
    );

    nand_rb_watch #(.TMO_W(TMO_W), .SYNC_STAGES(SYNC_STAGES)) u_rb (
        .clk        (clk),
        .rst_n      (rst_n),
        .rb_n_async (nf_rb_n),
        .waiting    (state_q == ST_WAIT_RDY),
        .limit      (cfg_busy_limit),
        .rb_ok      (rb_ok),
        .tmo        (tmo)
    );

    nand_len_ctr #(.LEN_W(LEN_W), .PAGE_SMALL(PAGE_SMALL), .PAGE_BIG(PAGE_BIG)) u_len (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .single   (nand_op_e'(req_op) == OP_CMD),
        .page_big (cfg_page_big),
        .req_len  (req_len),
        .dec      (dec_len),
        .last     (last)
    );

    // next-state and handshake strobes
    always_comb begin
        state_d = state_q;
        accept  = 1'b0;
        take_tx = 1'b0;
        cap_rx  = 1'b0;
        dec_len = 1'b0;
        set_err = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    accept = 1'b1;
                    unique case (nand_op_e'(req_op))
                        OP_CMD:  state_d = ST_WAIT_RDY;
                        OP_READ: state_d = ST_RD_LO;
                        default: state_d = ST_FETCH;
                    endcase
                end
            end
            ST_WAIT_RDY: begin
                if (tmo) begin
                    set_err = 1'b1;
                    state_d = ST_IDLE;
                end else if (rb_ok) begin
                    state_d = ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (tx_valid) begin
                    take_tx = 1'b1;
                    state_d = ST_SETUP;
                end
            end
            ST_SETUP: if (ph_done) state_d = ST_WR_LO;
            ST_WR_LO: if (ph_done) state_d = ST_WR_HI;
            ST_WR_HI: begin
                if (ph_done) begin
                    if (last) begin
                        state_d = ST_IDLE;
                    end else begin
                        dec_len = 1'b1;
                        state_d = ST_FETCH;
                    end
                end
            end
            ST_RD_LO: begin
                if (ph_done) begin
                    cap_rx  = 1'b1;
                    state_d = ST_RD_HI;
                end
            end
            ST_RD_HI: if (ph_done) state_d = ST_RX_OUT;
            ST_RX_OUT: begin
                if (rx_ready) begin
                    if (last) begin
                        state_d = ST_IDLE;
                    end else begin
                        dec_len = 1'b1;
                        state_d = ST_RD_LO;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and request context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= OP_CMD;
            cs_q    <= '0;
            byte_q  <= '0;
            rx_q    <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                op_q  <= nand_op_e'(req_op);
                cs_q  <= req_cs;
                err_q <= 1'b0;
            end
            if (set_err) err_q  <= 1'b1;
            if (take_tx) byte_q <= tx_data;
            if (cap_rx)  rx_q   <= nf_dq_in;
        end
    end

    // output decode from the registered state
    always_comb begin
        req_ready = 1'b0;
        tx_ready  = 1'b0;
        rx_valid  = 1'b0;
        drive_bus = 1'b0;
        nf_we_n   = 1'b1;
        nf_re_n   = 1'b1;
        nf_ce_n   = '1;
        unique case (state_q)
            ST_IDLE:     req_ready = 1'b1;
            ST_WAIT_RDY: ;
            ST_FETCH:    tx_ready  = 1'b1;
            ST_SETUP:    drive_bus = 1'b1;
            ST_WR_LO: begin
                drive_bus = 1'b1;
                nf_we_n   = 1'b0;
            end
            ST_WR_HI:    drive_bus = 1'b1;
            ST_RD_LO:    nf_re_n   = 1'b0;
            ST_RD_HI:    ;
            ST_RX_OUT:   rx_valid  = 1'b1;
            default:     ;
        endcase
        if (state_q != ST_IDLE) nf_ce_n[cs_q] = 1'b0;
    end

    assign nf_dq_oe  = drive_bus;
    assign nf_cle    = drive_bus && (op_q == OP_CMD);
    assign nf_ale    = drive_bus && (op_q == OP_ADDR);
    assign nf_dq_out = byte_q;
    assign rx_data   = rx_q;
    assign busy_err  = err_q;

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (&nf_ce_n && nf_we_n && nf_re_n && !nf_dq_oe && !nf_cle && !nf_ale));

    // R2
    ce_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~nf_ce_n));

    // R3
    cle_ale_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(nf_cle && nf_ale));

    // R6
    read_bus_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !nf_re_n |-> !nf_dq_oe);

    // R8
    latch_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nf_we_n) |-> ($stable(nf_cle) && $stable(nf_ale) && $stable(nf_dq_out) && nf_dq_oe));

    // R11
    err_from_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_err) |-> $past(state_q == ST_WAIT_RDY));

    // R11
    err_abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_err) |-> (&nf_ce_n && nf_we_n));

endmodule

// File: tb/nand_bus_seq_tb.sv
module nand_bus_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'd0;
    logic [2:0]  req_cs = 3'd0;
    logic [11:0] req_len = 12'd0;
    logic [7:0]  tx_data = 8'd0;
    logic        tx_valid = 1'b0;
    logic        tx_ready;
    logic [7:0]  rx_data;
    logic        rx_valid;
    logic        rx_ready = 1'b1;
    logic [1:0]  cfg_grade = 2'd0;
    logic [7:0]  cfg_ph_fast = 8'd1;
    logic [7:0]  cfg_ph_mid = 8'd3;
    logic [7:0]  cfg_ph_slow = 8'd6;
    logic        cfg_page_big = 1'b0;
    logic [15:0] cfg_busy_limit = 16'd500;
    logic        busy_err;
    logic        nf_rb_n;
    logic [7:0]  nf_ce_n;
    logic        nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe;
    logic [7:0]  nf_dq_out;
    logic [7:0]  nf_dq_in = 8'd0;

    always #4 clk = ~clk;

    nand_bus_seq dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_cs(req_cs), .req_len(req_len),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .cfg_grade(cfg_grade), .cfg_ph_fast(cfg_ph_fast), .cfg_ph_mid(cfg_ph_mid),
        .cfg_ph_slow(cfg_ph_slow), .cfg_page_big(cfg_page_big),
        .cfg_busy_limit(cfg_busy_limit), .busy_err(busy_err),
        .nf_rb_n(nf_rb_n), .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale),
        .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .nf_dq_out(nf_dq_out),
        .nf_dq_oe(nf_dq_oe), .nf_dq_in(nf_dq_in)
    );

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    // bench-side bus observation
    bit        rb_drive = 1'b1;
    assign nf_rb_n = rb_drive;
    logic [7:0] tx_buf [0:4095];
    logic [7:0] lg_dq  [0:4095];
    logic [7:0] lg_ce  [0:4095];
    logic       lg_cle [0:4095];
    logic       lg_ale [0:4095];
    logic       lg_oe  [0:4095];
    logic [7:0] rx_log [0:4095];
    int  we_rise, re_fall, rx_n, rd_idx, tx_idx;
    int  we_low, re_low, w_bad, r_bad, busy_falls, exp_p;
    bit  tx_pend, tx_gap, rx_stall;
    bit  prev_we = 1'b1, prev_re = 1'b1;
    logic [7:0] rd_salt = 8'd0;

    function automatic logic [7:0] pat(input int i, input logic [7:0] salt);
        return 8'((i * 29 + int'(salt)) ^ (i >> 3));
    endfunction

    function automatic int phase_of(input int g, input int f, input int m, input int s);
        int v;
        v = (g == 0) ? f : (g == 1) ? m : s;
        return (v == 0) ? 1 : v;
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 190000) begin
            total++;
            bad++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    always @(negedge clk) begin
        // write strobe monitor
        if (!nf_we_n) we_low++;
        if (!nf_we_n && prev_we && !rb_drive) busy_falls++;
        if (nf_we_n && !prev_we) begin
            lg_dq[we_rise]  = nf_dq_out;
            lg_ce[we_rise]  = nf_ce_n;
            lg_cle[we_rise] = nf_cle;
            lg_ale[we_rise] = nf_ale;
            lg_oe[we_rise]  = nf_dq_oe;
            if (we_low != exp_p) w_bad++;
            we_rise++;
            we_low = 0;
        end
        prev_we = nf_we_n;
        // read strobe and flash data model
        if (!nf_re_n) re_low++;
        if (!nf_re_n && prev_re) begin
            nf_dq_in = pat(rd_idx, rd_salt);
            rd_idx++;
            re_fall++;
        end
        if (nf_re_n && !prev_re) begin
            if (re_low != exp_p) r_bad++;
            re_low = 0;
        end
        prev_re = nf_re_n;
        // transmit source
        if (tx_pend) begin
            tx_idx++;
            tx_pend = 1'b0;
        end
        tx_data  = tx_buf[tx_idx];
        tx_valid = tx_gap ? (($urandom % 4) != 0) : 1'b1;
        if (tx_valid && tx_ready) tx_pend = 1'b1;
        // receive sink
        rx_ready = rx_stall ? (($urandom % 3) != 0) : 1'b1;
        if (rx_valid && rx_ready) begin
            rx_log[rx_n] = rx_data;
            rx_n++;
        end
    end

    task automatic check_idle(input string tag);
        chk(req_ready == 1'b1, tag, "idle req_ready", int'(req_ready), 1);
        chk(nf_ce_n == 8'hFF && nf_we_n && nf_re_n && !nf_cle && !nf_ale && !nf_dq_oe,
            tag, "idle bus {ce_n,we,re,cle,ale,oe}",
            int'({nf_ce_n, nf_we_n, nf_re_n, nf_cle, nf_ale, nf_dq_oe}),
            int'({8'hFF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}));
    endtask

    task automatic start_req(input int op, input int cs, input int len, input bit gap, input bit stall);
        @(negedge clk);
        for (int i = 0; i < 4096; i++) tx_buf[i] = 8'($urandom);
        we_rise = 0; re_fall = 0; rx_n = 0; rd_idx = 0; tx_idx = 0; tx_pend = 1'b0;
        w_bad = 0; r_bad = 0; busy_falls = 0; we_low = 0; re_low = 0;
        rd_salt = 8'($urandom);
        exp_p = phase_of(int'(cfg_grade), int'(cfg_ph_fast), int'(cfg_ph_mid), int'(cfg_ph_slow));
        tx_gap = gap; rx_stall = stall;
        req_op = 2'(op); req_cs = 3'(cs); req_len = 12'(len);
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic finish_req();
        while (!req_ready) @(negedge clk);
    endtask

    task automatic check_log(input int op, input int cs, input int len);
        int pmax, n, mism, ce_mism, fi;
        string tag;
        pmax = cfg_page_big ? 2047 : 511;
        n = (op == 0) ? 1 : ((len > pmax) ? pmax : len) + 1;
        tag = (op == 0) ? "R3" : (op == 1) ? "R4" : (op == 2) ? "R5" : "R6";
        mism = 0; ce_mism = 0; fi = -1;
        if (op == 3) begin
            chk(re_fall == n && we_rise == 0, tag, "read strobe count", re_fall, n);
            chk(rx_n == n, tag, "rx byte count", rx_n, n);
            for (int i = 0; i < n && i < rx_n; i++)
                if (rx_log[i] != pat(i, rd_salt)) begin mism++; if (fi < 0) fi = i; end
            chk(mism == 0, tag, "rx byte mismatches (R12 order)", mism, 0);
            chk(r_bad == 0, "R7", "re_n low width errors", r_bad, 0);
        end else begin
            chk(we_rise == n && re_fall == 0, tag, "write strobe count", we_rise, n);
            for (int i = 0; i < n && i < we_rise; i++) begin
                if (lg_dq[i] != tx_buf[i] || lg_cle[i] != (op == 0) || lg_ale[i] != (op == 1) || !lg_oe[i]) begin
                    mism++;
                    if (fi < 0) fi = i;
                end
                if (lg_ce[i] != ~(8'd1 << cs)) ce_mism++;
            end
            chk(mism == 0, tag, "latched byte/strobe mismatches (R12 order)", mism, 0);
            chk(ce_mism == 0, "R2", "chip enable mismatches", ce_mism, 0);
            chk(w_bad == 0, "R7", "we_n low width errors", w_bad, 0);
        end
        check_idle("R1");
    endtask

    task automatic run_req(input int op, input int cs, input int len, input bit gap, input bit stall);
        start_req(op, cs, len, gap, stall);
        finish_req();
        check_log(op, cs, len);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4096; i++) tx_buf[i] = 8'd0;
        exp_p = 1;
        repeat (5) @(negedge clk);
        // R1 reset state
        check_idle("R1");
        chk(busy_err == 1'b0, "R1", "busy_err after reset", int'(busy_err), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check_idle("R1");

        // R3 command ignores length, grade 0
        cfg_grade = 2'd0;
        run_req(0, 3, 5, 1'b0, 1'b0);
        // R4 address bytes, grade 1
        cfg_grade = 2'd1;
        run_req(1, 5, 4, 1'b0, 1'b0);
        // R5 write, grade 2
        cfg_grade = 2'd2;
        run_req(2, 7, 20, 1'b1, 1'b0);
        // R7 grade 3 uses the slow count
        cfg_grade = 2'd3;
        run_req(2, 0, 6, 1'b0, 1'b0);
        // R6 read with receiver stalls
        cfg_grade = 2'd1;
        run_req(3, 2, 30, 1'b0, 1'b1);
        // R7 zero phase count acts as one
        cfg_ph_fast = 8'd0; cfg_grade = 2'd0;
        run_req(2, 1, 9, 1'b0, 1'b0);
        run_req(3, 6, 9, 1'b0, 1'b0);

        // R9 page caps
        cfg_ph_fast = 8'd1; cfg_grade = 2'd0;
        cfg_page_big = 1'b0;
        run_req(2, 4, 1000, 1'b0, 1'b0);
        run_req(1, 4, 600, 1'b0, 1'b0);
        cfg_page_big = 1'b1;
        run_req(3, 2, 3000, 1'b0, 1'b0);
        run_req(2, 3, 700, 1'b0, 1'b0);

        // R10 command waits for ready
        cfg_busy_limit = 16'd500;
        rb_drive = 1'b0;
        start_req(0, 6, 0, 1'b0, 1'b0);
        repeat (40) @(negedge clk);
        chk(req_ready == 1'b0 && we_rise == 0, "R10", "strobes while busy", we_rise, 0);
        chk(nf_ce_n == ~(8'd1 << 6), "R2", "chip enable during ready wait", int'(nf_ce_n), int'(~(8'd1 << 6)));
        rb_drive = 1'b1;
        finish_req();
        chk(busy_falls == 0, "R10", "we_n falls while busy", busy_falls, 0);
        chk(busy_err == 1'b0, "R10", "busy_err after normal wait", int'(busy_err), 0);
        check_log(0, 6, 0);

        // R11 ready timeout
        cfg_busy_limit = 16'd30;
        rb_drive = 1'b0;
        start_req(0, 2, 0, 1'b0, 1'b0);
        finish_req();
        chk(busy_err == 1'b1, "R11", "busy_err after timeout", int'(busy_err), 1);
        chk(we_rise == 0, "R11", "strobes on dropped command", we_rise, 0);
        check_idle("R11");
        rb_drive = 1'b1;
        cfg_busy_limit = 16'd500;
        repeat (4) @(negedge clk);
        chk(busy_err == 1'b1, "R11", "busy_err held until next request", int'(busy_err), 1);
        start_req(0, 2, 0, 1'b0, 1'b0);
        chk(busy_err == 1'b0, "R11", "busy_err cleared on accept", int'(busy_err), 0);
        finish_req();
        check_log(0, 2, 0);

        // random mix with stream stalls (R12)
        cfg_ph_fast = 8'd2; cfg_ph_mid = 8'd3; cfg_ph_slow = 8'd5;
        for (int k = 0; k < 30; k++) begin
            int op, cs, len;
            op = int'($urandom % 4);
            cs = int'($urandom % 8);
            len = int'($urandom % 48);
            cfg_grade = 2'($urandom);
            cfg_page_big = 1'($urandom);
            run_req(op, cs, len, 1'($urandom), 1'($urandom));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule